// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page translations for a memory management unit. It holds a parameterised number of entries, each tagged with a virtual page-pair number, an 8-bit address-space tag, a per-entry page mask and a global flag. Each entry carries two physical frame slots: one for the even page and one for the odd page of the pair. Each slot has its own 3-bit cache attribute, dirty flag and valid flag. Every live entry is compared with the request in parallel.

A lookup port takes a full virtual address and an address-space tag. It returns, in the same cycle, a hit flag, the winning index and the fields of the slot picked by the address bit just above the page offset. The same port flags addresses in the uncached window. A probe port takes a page-pair number and a tag. It returns the matching index, or an all-ones miss code. Software fills entries through an indexed write port and reads them back packed through an indexed read port. Reads can instead use a round-robin replacement pointer, and may advance that pointer. A flush strobe clears everything in one cycle.

Top module: `tlb_assoc`

## Requirements
- R1: An entry matches only on the page-pair number bits where its mask bit is 0. Bits where its mask bit is 1 are ignored.
- R2: A match also needs the entry's global flag set, or the request tag equal to the stored tag.
- R3: `pr_idx` is `{1'b0, index}` of the matching entry. With no match it is all ones.
- R4: An entry takes part in matching only when at least one of its two slot valid flags is set.
- R5: When several entries match, lookup and probe both report the lowest-numbered one.
- R6: A write with `wr_idx` below N replaces the whole entry, and the new entry is visible from the next cycle. A write with `wr_idx` at or above N changes no entry and sets `wr_warn` for exactly the next cycle.
- R7: A flush leaves every entry all-zero from the next cycle and returns `rplc_ptr` to 0. Flush takes priority over a write in the same cycle.
- R8: The read port packs each slot word as frame<<6 | attr<<3 | dirty<<2 | valid<<1 | global. `rd_hi` is vpn<<11 | tag, and `rd_mask_word` is mask<<11.
- R9: With `rd_use_ptr` high, the read port shows the entry at `rplc_ptr`. If `rd_advance` is also high, the pointer steps by one per cycle and wraps from N-1 to 0. Otherwise it holds.
- R10: `lk_uncached` is 1 exactly when `lk_va` has bits 31 and 29 both set, whether or not the lookup hits.
- R11: On a hit, the lookup outputs come from the even slot when `lk_va[12]` is 0 and from the odd slot when it is 1. `lk_valid` shows that slot's own valid flag. On a miss, all slot outputs are 0.
- R12: After reset, no entry is live, `rplc_ptr` is 0 and `wr_warn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | Lookup matched a live entry |
| lk_idx | output | 4 | Index of the winning entry |
| lk_pfn | output | 20 | Frame number of the selected slot |
| lk_attr | output | 3 | Cache attribute of the selected slot |
| lk_dirty | output | 1 | Dirty flag of the selected slot |
| lk_valid | output | 1 | Valid flag of the selected slot |
| lk_uncached | output | 1 | Address lies in the uncached window |
| pr_vpn | input | 19 | Probe page-pair number |
| pr_asid | input | 8 | Probe address-space tag |
| pr_idx | output | 5 | Probe result, or all ones on a miss |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | 5 | Write index (may be out of range) |
| wr_vpn | input | 19 | Page-pair number to write |
| wr_asid | input | 8 | Tag to write |
| wr_mask | input | 19 | Page mask to write |
| wr_global | input | 1 | Global flag to write |
| wr_pfn0 | input | 20 | Even slot frame number |
| wr_attr0 | input | 3 | Even slot attribute |
| wr_dirty0 | input | 1 | Even slot dirty flag |
| wr_valid0 | input | 1 | Even slot valid flag |
| wr_pfn1 | input | 20 | Odd slot frame number |
| wr_attr1 | input | 3 | Odd slot attribute |
| wr_dirty1 | input | 1 | Odd slot dirty flag |
| wr_valid1 | input | 1 | Odd slot valid flag |
| wr_warn | output | 1 | Previous cycle's write was out of range |
| rd_idx | input | 4 | Read index when the pointer is not used |
| rd_use_ptr | input | 1 | Read the entry at the replacement pointer |
| rd_advance | input | 1 | With rd_use_ptr, step the pointer |
| rd_hi | output | 30 | Packed page-pair number and tag |
| rd_lo0 | output | 26 | Packed even slot word |
| rd_lo1 | output | 26 | Packed odd slot word |
| rd_mask_word | output | 30 | Mask shifted left by 11 |
| rplc_ptr | output | 4 | Round-robin replacement pointer |
| flush | input | 1 | Clear all entries and the pointer |

## Verification
Lookups are run with an exact page-pair match, with an address that differs only inside an entry's mask, and with one that differs just outside it. Together these show whether the mask gates the right bits. The tag is tried equal, unequal, and unequal against a global entry, which separates tag matching from the global override. Duplicate entries and a non-live entry placed below a live one show whether the lowest-index priority and the live gating are right. Even and odd address bits show whether slot selection is right. Out-of-range, boundary, pointer-wrap and flush sequences are then read back through the lookup, probe and read ports.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // slot word layout: {pfn, attr, dirty, valid}
  localparam int ATTR_W       = 3;
  localparam int SLOT_V_BIT   = 0;
  localparam int SLOT_D_BIT   = 1;
  localparam int SLOT_ATTR_LO = 2;
  localparam int SLOT_FLAGS_W = ATTR_W + 2;
  // left shift applied to page-pair number and mask on readback
  localparam int HI_SHIFT     = 11;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 16,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int SLOT_W = 25,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_ok,
  input  logic [IDX_W-1:0]  wr_pos,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic              wr_glb,
  input  logic [SLOT_W-1:0] wr_slot0,
  input  logic [SLOT_W-1:0] wr_slot1,
  output logic [VPN_W-1:0]  e_vpn   [N],
  output logic [ASID_W-1:0] e_asid  [N],
  output logic [VPN_W-1:0]  e_mask  [N],
  output logic [N-1:0]      e_glb,
  output logic [SLOT_W-1:0] e_slot0 [N],
  output logic [SLOT_W-1:0] e_slot1 [N],
  output logic [N-1:0]      e_live
);
  import tlb_pkg::*;

  logic [N-1:0] ent_en;
  logic [N-1:0] ent_clr;

  // per-entry clock enables
  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_clr[i] = flush;
      ent_en[i]  = flush || (wr_ok && (wr_pos == IDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        e_vpn[i]   <= '0;
        e_asid[i]  <= '0;
        e_mask[i]  <= '0;
        e_glb[i]   <= 1'b0;
        e_slot0[i] <= '0;
        e_slot1[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ent_en[i]) begin
          e_vpn[i]   <= ent_clr[i] ? '0   : wr_vpn;
          e_asid[i]  <= ent_clr[i] ? '0   : wr_asid;
          e_mask[i]  <= ent_clr[i] ? '0   : wr_mask;
          e_glb[i]   <= ent_clr[i] ? 1'b0 : wr_glb;
          e_slot0[i] <= ent_clr[i] ? '0   : wr_slot0;
          e_slot1[i] <= ent_clr[i] ? '0   : wr_slot1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      e_live[i] = e_slot0[i][SLOT_V_BIT] | e_slot1[i][SLOT_V_BIT];
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  e_vpn  [N],
  input  logic [ASID_W-1:0] e_asid [N],
  input  logic [VPN_W-1:0]  e_mask [N],
  input  logic [N-1:0]      e_glb,
  input  logic [N-1:0]      e_live,
  output logic [N-1:0]      hits
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic vpn_eq;
    logic tag_ok;
    assign vpn_eq  = ((q_vpn ^ e_vpn[g]) & ~e_mask[g]) == '0;
    assign tag_ok  = e_glb[g] || (q_asid == e_asid[g]);
    assign hits[g] = e_live[g] && vpn_eq && tag_ok;
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N      = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hits[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N      = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_nxt;
  logic             ptr_en;

  always_comb begin
    ptr_en  = flush || adv;
    ptr_nxt = ptr;
    if (flush)            ptr_nxt = '0;
    else if (ptr == LAST) ptr_nxt = '0;
    else                  ptr_nxt = ptr + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int N          = 16,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8,
  parameter int PFN_W      = 20,
  parameter logic [VA_W-1:0] UNC_PAT = 32'hA000_0000,
  localparam int IDX_W  = $clog2(N),
  localparam int PIDX_W = IDX_W + 1,
  localparam int VPN_W  = VA_W - PAGE_SHIFT - 1,
  localparam int HI_W   = VPN_W + tlb_pkg::HI_SHIFT,
  localparam int LO_W   = PFN_W + tlb_pkg::SLOT_FLAGS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_attr,
  output logic              lk_dirty,
  output logic              lk_valid,
  output logic              lk_uncached,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [PIDX_W-1:0] pr_idx,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [2:0]        wr_attr0,
  input  logic              wr_dirty0,
  input  logic              wr_valid0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic [2:0]        wr_attr1,
  input  logic              wr_dirty1,
  input  logic              wr_valid1,
  output logic              wr_warn,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_use_ptr,
  input  logic              rd_advance,
  output logic [HI_W-1:0]   rd_hi,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  output logic [HI_W-1:0]   rd_mask_word,
  output logic [IDX_W-1:0]  rplc_ptr,
  input  logic              flush
);
  import tlb_pkg::*;

  localparam int SLOT_W = PFN_W + SLOT_FLAGS_W;
  localparam logic [PIDX_W-1:0] N_P = PIDX_W'(N);

  logic [VPN_W-1:0]  e_vpn   [N];
  logic [ASID_W-1:0] e_asid  [N];
  logic [VPN_W-1:0]  e_mask  [N];
  logic [N-1:0]      e_glb;
  logic [SLOT_W-1:0] e_slot0 [N];
  logic [SLOT_W-1:0] e_slot1 [N];
  logic [N-1:0]      e_live;

  // write path
  logic wr_in_range, wr_ok, warn_nxt;
  logic [SLOT_W-1:0] wr_slot0, wr_slot1;

  assign wr_in_range = wr_idx < N_P;
  assign wr_ok       = wr_en && wr_in_range && !flush;
  assign wr_slot0    = {wr_pfn0, wr_attr0, wr_dirty0, wr_valid0};
  assign wr_slot1    = {wr_pfn1, wr_attr1, wr_dirty1, wr_valid1};

  tlb_store #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .SLOT_W(SLOT_W)) i_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_ok(wr_ok),
    .wr_pos(wr_idx[IDX_W-1:0]), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_mask(wr_mask), .wr_glb(wr_global), .wr_slot0(wr_slot0), .wr_slot1(wr_slot1),
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_glb(e_glb),
    .e_slot0(e_slot0), .e_slot1(e_slot1), .e_live(e_live)
  );

  always_comb warn_nxt = wr_en && !wr_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_warn <= 1'b0;
    else        wr_warn <= warn_nxt;
  end

  // lookup and probe comparator arrays
  logic [VPN_W-1:0] lk_vpn;
  logic             lk_odd;
  logic [N-1:0]     lk_hits, pr_hits;
  logic             pr_any;
  logic [IDX_W-1:0] pr_win;

  assign lk_vpn = lk_va[VA_W-1 -: VPN_W];
  assign lk_odd = lk_va[PAGE_SHIFT];

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_lk_match (
    .q_vpn(lk_vpn), .q_asid(lk_asid), .e_vpn(e_vpn), .e_asid(e_asid),
    .e_mask(e_mask), .e_glb(e_glb), .e_live(e_live), .hits(lk_hits)
  );
  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_pr_match (
    .q_vpn(pr_vpn), .q_asid(pr_asid), .e_vpn(e_vpn), .e_asid(e_asid),
    .e_mask(e_mask), .e_glb(e_glb), .e_live(e_live), .hits(pr_hits)
  );
  tlb_prio_enc #(.N(N)) i_lk_enc (.hits(lk_hits), .any(lk_hit), .idx(lk_idx));
  tlb_prio_enc #(.N(N)) i_pr_enc (.hits(pr_hits), .any(pr_any), .idx(pr_win));

  assign pr_idx = pr_any ? {1'b0, pr_win} : '1;

  // slot selection for the lookup result
  logic [SLOT_W-1:0] lk_slot;
  always_comb begin
    lk_slot = '0;
    if (lk_hit) lk_slot = lk_odd ? e_slot1[lk_idx] : e_slot0[lk_idx];
  end
  assign lk_pfn      = lk_slot[SLOT_W-1 -: PFN_W];
  assign lk_attr     = lk_slot[SLOT_ATTR_LO +: ATTR_W];
  assign lk_dirty    = lk_slot[SLOT_D_BIT];
  assign lk_valid    = lk_slot[SLOT_V_BIT];
  assign lk_uncached = (lk_va & UNC_PAT) == UNC_PAT;

  // replacement pointer and read port
  tlb_rr_ptr #(.N(N)) i_ptr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .adv(rd_use_ptr && rd_advance), .ptr(rplc_ptr)
  );

  logic [IDX_W-1:0] rd_sel;
  assign rd_sel       = rd_use_ptr ? rplc_ptr : rd_idx;
  assign rd_hi        = {e_vpn[rd_sel], {(HI_SHIFT-ASID_W){1'b0}}, e_asid[rd_sel]};
  assign rd_lo0       = {e_slot0[rd_sel], e_glb[rd_sel]};
  assign rd_lo1       = {e_slot1[rd_sel], e_glb[rd_sel]};
  assign rd_mask_word = {e_mask[rd_sel], {HI_SHIFT{1'b0}}};
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int N          = 16,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8,
  localparam int IDX_W  = $clog2(N),
  localparam int PIDX_W = IDX_W + 1,
  localparam int VPN_W  = VA_W - PAGE_SHIFT - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              wr_en,
  input logic [PIDX_W-1:0] wr_idx,
  input logic              wr_warn,
  input logic [VA_W-1:0]   lk_va,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [VPN_W-1:0]  pr_vpn,
  input logic [ASID_W-1:0] pr_asid,
  input logic [PIDX_W-1:0] pr_idx,
  input logic              rd_use_ptr,
  input logic              rd_advance,
  input logic [IDX_W-1:0]  rplc_ptr
);
  localparam logic [PIDX_W-1:0] N_P  = PIDX_W'(N);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(N - 1);
  localparam logic [IDX_W-1:0]  ONE  = IDX_W'(1);

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rplc_ptr == '0) && !lk_hit);

  // R6
  oor_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= N_P) |=> wr_warn);

  // R6
  warn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx >= N_P) |=> !wr_warn);

  // R3
  probe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_idx < N_P) || (pr_idx == '1));

  // R3
  probe_lookup_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pr_vpn == lk_va[VA_W-1 -: VPN_W]) && (pr_asid == lk_asid)) |->
      ((lk_hit == (pr_idx != '1)) && (!lk_hit || (pr_idx == {1'b0, lk_idx}))));

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && rd_use_ptr && rd_advance) |=>
      (rplc_ptr == (($past(rplc_ptr) == LAST) ? '0 : $past(rplc_ptr) + ONE)));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(rd_use_ptr && rd_advance)) |=> $stable(rplc_ptr));
endmodule

bind tlb_assoc tlb_assoc_chk #(.N(N), .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_warn(wr_warn), .lk_va(lk_va), .lk_asid(lk_asid), .lk_hit(lk_hit),
  .lk_idx(lk_idx), .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_idx(pr_idx),
  .rd_use_ptr(rd_use_ptr), .rd_advance(rd_advance), .rplc_ptr(rplc_ptr)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_hit;
  logic [3:0]  lk_idx;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_attr;
  logic        lk_dirty, lk_valid, lk_uncached;
  logic [18:0] pr_vpn;
  logic [7:0]  pr_asid;
  logic [4:0]  pr_idx;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [18:0] wr_vpn, wr_mask;
  logic [7:0]  wr_asid;
  logic        wr_global;
  logic [19:0] wr_pfn0, wr_pfn1;
  logic [2:0]  wr_attr0, wr_attr1;
  logic        wr_dirty0, wr_valid0, wr_dirty1, wr_valid1;
  logic        wr_warn;
  logic [3:0]  rd_idx;
  logic        rd_use_ptr, rd_advance;
  logic [29:0] rd_hi, rd_mask_word;
  logic [25:0] rd_lo0, rd_lo1;
  logic [3:0]  rplc_ptr;
  logic        flush;

  always #2 clk = ~clk;

  tlb_assoc i_tlb_assoc (.*);

  localparam int S_HIT = 0, S_IDX = 1, S_PFN = 2, S_ATTR = 3, S_DIRTY = 4,
                 S_VALID = 5, S_UNC = 6, S_PR = 7, S_WARN = 8, S_PTR = 9,
                 S_HI = 10, S_LO0 = 11, S_LO1 = 12, S_MASK = 13;

  typedef struct {
    string       req;
    int          sig;
    logic [63:0] exp;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic logic [63:0] actual(int sig);
    case (sig)
      S_HIT:   return 64'(lk_hit);
      S_IDX:   return 64'(lk_idx);
      S_PFN:   return 64'(lk_pfn);
      S_ATTR:  return 64'(lk_attr);
      S_DIRTY: return 64'(lk_dirty);
      S_VALID: return 64'(lk_valid);
      S_UNC:   return 64'(lk_uncached);
      S_PR:    return 64'(pr_idx);
      S_WARN:  return 64'(wr_warn);
      S_PTR:   return 64'(rplc_ptr);
      S_HI:    return 64'(rd_hi);
      S_LO0:   return 64'(rd_lo0);
      S_LO1:   return 64'(rd_lo1);
      default: return 64'(rd_mask_word);
    endcase
  endfunction

  // monitor: compares queued expectations 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] a;
      it = q.pop_front();
      a  = actual(it.sig);
      n_checks++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s sig %0d: got %h expected %h", it.req, it.sig, a, it.exp);
      end
    end
  end

  function automatic logic [63:0] lo_word(logic [19:0] pfn, logic [2:0] at,
                                          logic d, logic v, logic g);
    return (64'(pfn) << 6) | (64'(at) << 3) | (64'(d) << 2) | (64'(v) << 1) | 64'(g);
  endfunction
  function automatic logic [63:0] hi_word(logic [18:0] vpn, logic [7:0] asid);
    return (64'(vpn) << 11) | 64'(asid);
  endfunction
  function automatic logic [31:0] va_of(logic [18:0] vpn, logic odd);
    return {vpn, odd, 12'h000};
  endfunction

  task automatic expect_v(string req, int sig, logic [63:0] v);
    item_t it;
    it.req = req; it.sig = sig; it.exp = v;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(logic [4:0] idx, logic [18:0] vpn, logic [7:0] asid,
                          logic [18:0] mask, logic g,
                          logic [19:0] p0, logic [2:0] a0, logic d0, logic v0,
                          logic [19:0] p1, logic [2:0] a1, logic d1, logic v1);
    tick();
    wr_en = 1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_mask = mask;
    wr_global = g; wr_pfn0 = p0; wr_attr0 = a0; wr_dirty0 = d0; wr_valid0 = v0;
    wr_pfn1 = p1; wr_attr1 = a1; wr_dirty1 = d1; wr_valid1 = v1;
    tick();
    wr_en = 0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid);
    lk_va = va; lk_asid = asid;
  endtask

  task automatic advance(int n);
    for (int k = 0; k < n; k++) begin
      tick();
      rd_use_ptr = 1; rd_advance = 1;
    end
    tick();
    rd_advance = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_va = 0; lk_asid = 0; pr_vpn = 0; pr_asid = 0;
    wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_asid = 0; wr_mask = 0; wr_global = 0;
    wr_pfn0 = 0; wr_attr0 = 0; wr_dirty0 = 0; wr_valid0 = 0;
    wr_pfn1 = 0; wr_attr1 = 0; wr_dirty1 = 0; wr_valid1 = 0;
    rd_idx = 0; rd_use_ptr = 0; rd_advance = 0; flush = 0;
    repeat (3) tick();
    rst_n = 1;

    // R12 reset state
    tick();
    expect_v("R12 hit", S_HIT, 0);
    expect_v("R12 probe", S_PR, 5'h1F);
    expect_v("R12 ptr", S_PTR, 0);
    expect_v("R12 warn", S_WARN, 0);
    expect_v("R12 lo0", S_LO0, 0);

    // entry 3: exact match, both slots
    do_write(5'd3, 19'h12345, 8'h05, 19'h0, 0,
             20'hABCDE, 3'd3, 1, 1, 20'h11111, 3'd2, 0, 1);
    look(va_of(19'h12345, 0), 8'h05);
    pr_vpn = 19'h12345; pr_asid = 8'h05;
    expect_v("R6 write hit", S_HIT, 1);
    expect_v("R11 even idx", S_IDX, 3);
    expect_v("R11 even pfn", S_PFN, 20'hABCDE);
    expect_v("R11 even attr", S_ATTR, 3);
    expect_v("R11 even dirty", S_DIRTY, 1);
    expect_v("R3 probe hit", S_PR, 3);
    expect_v("R10 low va", S_UNC, 0);
    tick();
    look(va_of(19'h12345, 1), 8'h05);
    expect_v("R11 odd pfn", S_PFN, 20'h11111);
    expect_v("R11 odd attr", S_ATTR, 2);
    expect_v("R11 odd dirty", S_DIRTY, 0);
    tick();
    look(va_of(19'h12345, 0), 8'h06);
    pr_asid = 8'h06;
    expect_v("R2 tag mismatch", S_HIT, 0);
    expect_v("R11 miss pfn", S_PFN, 0);
    expect_v("R3 probe miss", S_PR, 5'h1F);

    // R1 mask
    do_write(5'd5, 19'h00F00, 8'h09, 19'h000FF, 0,
             20'h00222, 3'd1, 0, 1, 20'h0, 3'd0, 0, 0);
    look(va_of(19'h00F00, 0), 8'h09);
    expect_v("R1 exact", S_IDX, 5);
    tick();
    look(va_of(19'h00F7A, 0), 8'h09);
    expect_v("R1 masked bits", S_HIT, 1);
    expect_v("R1 masked pfn", S_PFN, 20'h00222);
    tick();
    look(va_of(19'h01F00, 0), 8'h09);
    expect_v("R1 unmasked bit", S_HIT, 0);

    // R2 global
    do_write(5'd7, 19'h03000, 8'h01, 19'h0, 1,
             20'h00333, 3'd0, 0, 1, 20'h0, 3'd0, 0, 0);
    look(va_of(19'h03000, 0), 8'h55);
    expect_v("R2 global hit", S_HIT, 1);
    expect_v("R2 global idx", S_IDX, 7);

    // R4 live gating
    do_write(5'd9, 19'h04000, 8'h02, 19'h0, 0,
             20'h00444, 3'd0, 0, 0, 20'h00445, 3'd0, 0, 0);
    look(va_of(19'h04000, 0), 8'h02);
    pr_vpn = 19'h04000; pr_asid = 8'h02;
    expect_v("R4 dead hit", S_HIT, 0);
    expect_v("R4 dead probe", S_PR, 5'h1F);
    do_write(5'd10, 19'h04000, 8'h02, 19'h0, 0,
             20'h00555, 3'd0, 0, 0, 20'h00556, 3'd0, 0, 1);
    expect_v("R4 odd-live idx", S_IDX, 10);
    expect_v("R11 slot valid", S_VALID, 0);
    expect_v("R4 probe", S_PR, 10);

    // R5 priority
    do_write(5'd12, 19'h05000, 8'h03, 19'h0, 0,
             20'h00212, 3'd0, 0, 1, 20'h0, 3'd0, 0, 0);
    do_write(5'd2, 19'h05000, 8'h03, 19'h0, 0,
             20'h00202, 3'd0, 0, 1, 20'h0, 3'd0, 0, 0);
    look(va_of(19'h05000, 0), 8'h03);
    pr_vpn = 19'h05000; pr_asid = 8'h03;
    expect_v("R5 lowest idx", S_IDX, 2);
    expect_v("R5 lowest pfn", S_PFN, 20'h00202);
    expect_v("R5 probe", S_PR, 2);

    // R6 out-of-range writes
    do_write(5'd20, 19'h05000, 8'h03, 19'h0, 0,
             20'h00999, 3'd0, 0, 1, 20'h0, 3'd0, 0, 0);
    expect_v("R6 warn", S_WARN, 1);
    expect_v("R6 ignored", S_PFN, 20'h00202);
    tick();
    expect_v("R6 warn one cycle", S_WARN, 0);
    do_write(5'd16, 19'h05000, 8'h03, 19'h0, 0,
             20'h00998, 3'd0, 0, 1, 20'h0, 3'd0, 0, 0);
    expect_v("R6 boundary warn", S_WARN, 1);
    expect_v("R6 boundary ignored", S_IDX, 2);
    do_write(5'd2, 19'h06000, 8'h03, 19'h0, 0,
             20'h00606, 3'd0, 0, 1, 20'h0, 3'd0, 0, 0);
    expect_v("R6 replaced idx", S_IDX, 12);
    expect_v("R6 replaced pfn", S_PFN, 20'h00212);
    expect_v("R6 in-range no warn", S_WARN, 0);

    // R10 window with a hit, last index
    do_write(5'd15, 19'h50000, 8'h00, 19'h0, 1,
             20'h00777, 3'd2, 1, 1, 20'h0, 3'd0, 0, 0);
    look(32'hA000_0000, 8'h44);
    expect_v("R10 window hit", S_UNC, 1);
    expect_v("R10 last idx", S_IDX, 15);
    tick();
    look(32'hBFFF_0000, 8'h00);
    expect_v("R10 window", S_UNC, 1);
    tick();
    look(32'h8000_0000, 8'h00);
    expect_v("R10 bit31 only", S_UNC, 0);
    tick();
    look(32'h2000_0000, 8'h00);
    expect_v("R10 bit29 only", S_UNC, 0);

    // R8 packing
    tick();
    rd_idx = 4'd3;
    expect_v("R8 hi", S_HI, hi_word(19'h12345, 8'h05));
    expect_v("R8 lo0", S_LO0, lo_word(20'hABCDE, 3'd3, 1, 1, 0));
    expect_v("R8 lo1", S_LO1, lo_word(20'h11111, 3'd2, 0, 1, 0));
    tick();
    rd_idx = 4'd5;
    expect_v("R8 mask", S_MASK, 64'(19'h000FF) << 11);
    tick();
    rd_idx = 4'd7;
    expect_v("R8 global bit", S_LO0, lo_word(20'h00333, 3'd0, 0, 1, 1));

    // R9 pointer
    tick();
    rd_use_ptr = 1; rd_idx = 4'd3;
    expect_v("R9 ptr read", S_HI, 0);
    tick();
    expect_v("R9 hold", S_PTR, 0);
    advance(3);
    expect_v("R9 ptr 3", S_PTR, 3);
    expect_v("R9 ptr read 3", S_HI, hi_word(19'h12345, 8'h05));
    advance(12);
    expect_v("R9 ptr 15", S_PTR, 15);
    expect_v("R9 read 15", S_LO0, lo_word(20'h00777, 3'd2, 1, 1, 1));
    advance(1);
    expect_v("R9 wrap", S_PTR, 0);
    advance(1);
    expect_v("R9 after wrap", S_PTR, 1);

    // R7 flush, with a same-cycle write
    tick();
    rd_use_ptr = 0; rd_idx = 4'd3;
    flush = 1; wr_en = 1; wr_idx = 5'd4; wr_vpn = 19'h12345; wr_asid = 8'h05;
    wr_valid0 = 1; wr_global = 0; wr_mask = 0;
    tick();
    flush = 0; wr_en = 0;
    look(va_of(19'h12345, 0), 8'h05);
    pr_vpn = 19'h12345; pr_asid = 8'h05;
    expect_v("R7 ptr", S_PTR, 0);
    expect_v("R7 no hit", S_HIT, 0);
    expect_v("R7 probe", S_PR, 5'h1F);
    expect_v("R7 hi", S_HI, 0);
    expect_v("R7 lo0", S_LO0, 0);
    tick();
    rd_idx = 4'd4;
    expect_v("R7 flush beats write", S_LO0, 0);

    tick();
    tick();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule